// File: doc/BRIEF.md
# Round-Key Expansion Engine

This block turns a user key of 16, 24 or 32 bytes into a table of 44 round-key words of 32 bits each, ready for a block-cipher core. A start pulse copies the key into a small working array of key words. The engine then fills the table with a fixed arithmetic progression, one word per clock. After that it runs 132 mixing iterations, one per clock. Each iteration walks the 44-entry table and the 4-, 6- or 8-entry key array as two circular arrays of different lengths at the same time. Each iteration also uses a rotation whose amount depends on the data.

When the last iteration completes, the engine drops busy and pulses done for one cycle. A cipher core can then read any table word through a combinational indexed read port.

Top module: `key_expand_engine`

## Requirements
- R1: After reset, busy and done are both low.
- R2: A start that is sampled while idle raises busy on that same edge. Done is high for exactly one cycle, starting 176 rising edges after the start edge: 44 fill writes, then 132 mixing iterations. Busy falls on the edge where done rises.
- R3: The key length is set by klen: 0 means 16 bytes (4 words), 1 means 24 bytes (6 words), and 2 or 3 means 32 bytes (8 words). Key byte n sits at key[8n+7:8n], and byte 0 becomes the least significant byte of key word 0. Key bits above the selected length have no effect on the result.
- R4: The fill step writes word 0 as 0xB7E15163. Each following word is the previous word plus 0x9E3779B9, modulo 2^32.
- R5: In each mixing iteration, the accumulator a and table word i both take the value (table[i] + a + b) rotated left by 3. Then the accumulator b and key word j both take the value (key[j] + a + b) rotated left by the low 5 bits of (a + b), using the new a.
- R6: The accumulators and both indices start at zero. Index i wraps modulo 44 and index j wraps modulo the key word count. Exactly 132 iterations run.
- R7: A start that arrives while busy is ignored. It does not change the key in use or the completion time.
- R8: After done, rd_data shows table word rd_idx in the same cycle. An index of 44 or more reads as zero.
- R9: A new start after completion gives a fresh schedule for the new key, with no carry-over from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken only when idle |
| klen | input | 2 | Key length select |
| key | input | 256 | User key, byte 0 in the low bits |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | input | 6 | Table read index |
| rd_data | output | 32 | Table word at rd_idx |

## Verification
The only delayed result is completion. Done is due exactly 176 edges after the edge that samples start, so the bench counts edges from that edge and requires done in that cycle and nowhere else. The read port is combinational. The bench therefore sets rd_idx on a falling edge and samples rd_data on the same falling edge. Busy is checked in the cycle after start, and a second start is injected mid-run to confirm that completion time and table contents are unchanged.

// File: rtl/key_expand_engine.sv
module key_expand_engine #(
  parameter int W          = 32,
  parameter int TBL_WORDS  = 44,
  parameter int KEY_WMAX   = 8,
  parameter int PASSES     = 3,
  parameter logic [31:0] SEED = 32'hB7E15163,
  parameter logic [31:0] STEP = 32'h9E3779B9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              klen,
  input  logic [KEY_WMAX*W-1:0]   key,
  output logic                    busy,
  output logic                    done,
  input  logic [$clog2(TBL_WORDS)-1:0] rd_idx,
  output logic [W-1:0]            rd_data
);
  localparam int ITERS = PASSES * TBL_WORDS;
  localparam int IW    = $clog2(TBL_WORDS);
  localparam int JW    = $clog2(KEY_WMAX);
  localparam int CW    = $clog2(ITERS + 1);
  localparam int LGW   = $clog2(W);

  typedef enum logic [1:0] {IDLE, FILL, MIX} phase_t;

  phase_t         st;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  ti;
  logic [JW-1:0]  kj;
  logic [JW:0]    nkw;
  logic [W-1:0]   acc_a, acc_b, fill_v;
  logic [W-1:0]   tbl [TBL_WORDS];
  logic [W-1:0]   lw  [KEY_WMAX];
  logic [W-1:0]   a_nx, ab_sum, b_nx;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [LGW-1:0] r);
    logic [2*W-1:0] d;
    d = {x, x} << r;
    return d[2*W-1:W];
  endfunction

  assign a_nx   = rotl(tbl[ti] + acc_a + acc_b, LGW'(3));
  assign ab_sum = a_nx + acc_b;
  assign b_nx   = rotl(lw[kj] + ab_sum, ab_sum[LGW-1:0]);
  assign busy   = (st != IDLE);
  assign rd_data = (int'(rd_idx) < TBL_WORDS) ? tbl[rd_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; cnt <= '0; ti <= '0; kj <= '0;
      acc_a <= '0; acc_b <= '0; fill_v <= '0; nkw <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          nkw    <= (klen == 2'd0) ? (JW+1)'(4) : (klen == 2'd1) ? (JW+1)'(6) : (JW+1)'(8);
          fill_v <= SEED;
          cnt    <= '0;
          st     <= FILL;
        end
        FILL: begin
          fill_v <= fill_v + STEP;
          if (int'(cnt) == TBL_WORDS - 1) begin
            st <= MIX; cnt <= '0; ti <= '0; kj <= '0;
            acc_a <= '0; acc_b <= '0;
          end else cnt <= cnt + 1'b1;
        end
        MIX: begin
          acc_a <= a_nx;
          acc_b <= b_nx;
          ti <= (int'(ti) == TBL_WORDS - 1) ? '0 : ti + 1'b1;
          kj <= ({1'b0, kj} == nkw - 1'b1) ? '0 : kj + 1'b1;
          if (int'(cnt) == ITERS - 1) begin
            st <= IDLE; done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == IDLE && start) begin
      for (int k = 0; k < KEY_WMAX; k++) lw[k] <= key[k*W +: W];
    end else if (st == FILL) begin
      tbl[cnt[IW-1:0]] <= fill_v;
    end else if (st == MIX) begin
      tbl[ti] <= a_nx;
      lw[kj]  <= b_nx;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy));
  // R7
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start) && !$past(busy));
  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MIX) |-> (int'(ti) < TBL_WORDS) && ({1'b0, kj} < nkw));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy && !$past(busy) |-> !done);
endmodule

// File: tb/sim_key_expand_engine.sv
module sim_key_expand_engine;
  logic clk = 0, rst_n = 0, start = 0, busy, done;
  logic [1:0] klen = 0;
  logic [255:0] key = '0;
  logic [5:0] rd_idx = 0;
  logic [31:0] rd_data;
  int total = 0, bad = 0;
  logic [31:0] exp_s [44];

  always #10 clk = ~clk;

  key_expand_engine u0 (.clk(clk), .rst_n(rst_n), .start(start), .klen(klen), .key(key),
                        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data));

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog: run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] rl(input logic [31:0] x, input int r);
    r = r % 32;
    return (r == 0) ? x : ((x << r) | (x >> (32 - r)));
  endfunction

  task automatic model(input logic [255:0] k, input logic [1:0] len);
    logic [31:0] l [8];
    logic [31:0] a = 0, b = 0;
    int c, i = 0, j = 0;
    c = (len == 0) ? 4 : (len == 1) ? 6 : 8;
    for (int n = 0; n < 32; n++) l[n/4][8*(n%4) +: 8] = k[8*n +: 8];
    exp_s[0] = 32'hB7E15163;
    for (int n = 1; n < 44; n++) exp_s[n] = exp_s[n-1] + 32'h9E3779B9;
    for (int s = 0; s < 132; s++) begin
      a = rl(exp_s[i] + a + b, 3); exp_s[i] = a;
      b = rl(l[j] + a + b, int'((a + b) & 32'h1f)); l[j] = b;
      i = (i + 1) % 44; j = (j + 1) % c;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", req, act, expv); end
  endtask

  task automatic run(input logic [255:0] k, input logic [1:0] len, input bit inject, input string req);
    int cyc = 0, seen = -1, mism = 0;
    @(negedge clk); key = k; klen = len; start = 1;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R2 busy after start", 32'(busy), 1);
    while (cyc < 400) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (inject && cyc == 20) begin start = 1; key = ~k; klen = 2'd0; end
      else start = 0;
      if (done) begin
        if (seen < 0) seen = cyc;
        else seen = 9999;
      end
      if (seen > 0 && seen != 9999 && cyc == seen + 2) break;
    end
    start = 0;
    chk(seen == 176, {req, " done at cycle 176"}, 32'(seen), 176);
    chk(busy === 1'b0, {req, " busy low after done"}, 32'(busy), 0);
    model(k, len);
    for (int n = 0; n < 44; n++) begin
      rd_idx = 6'(n); #1;
      if (rd_data !== exp_s[n]) begin
        mism++;
        if (mism == 1) chk(0, {req, " table word"}, rd_data, exp_s[n]);
      end
      @(negedge clk);
    end
    if (mism == 0) chk(1, req, 0, 0);
  endtask

  initial begin
    logic [255:0] k;
    void'($urandom(32'd1234));
    #25;
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk(done === 1'b0, "R1 done", 32'(done), 0);
    rst_n = 1;
    // R4 R5 R6 all-zero 16-byte key
    run('0, 2'd0, 0, "R4 R5 R6 zero key");
    // R3 upper bits ignored for 16-byte key
    run({128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'h0}, 2'd0, 0, "R3 unused bits");
    // R3 byte order, 24 and 32 byte keys, klen 3
    for (int n = 0; n < 32; n++) k[8*n +: 8] = 8'(n);
    run(k, 2'd1, 0, "R3 24-byte key");
    run(k, 2'd2, 0, "R3 32-byte key");
    run(k, 2'd3, 0, "R3 klen 3 as 32-byte");
    // R7 start during busy ignored
    run(k, 2'd2, 1, "R7 start while busy");
    // R9 random keys back to back
    for (int t = 0; t < 6; t++) begin
      for (int w = 0; w < 8; w++) k[32*w +: 32] = $urandom;
      run(k, 2'(t % 3), 0, "R9 R5 random key");
    end
    // R8 out-of-range index
    @(negedge clk); rd_idx = 6'd50; #1;
    chk(rd_data === 32'h0, "R8 out-of-range read", rd_data, 0);
    rd_idx = 6'd43; #1;
    chk(rd_data === exp_s[43], "R8 last word", rd_data, exp_s[43]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule